// File: doc/BRIEF.md
# LED Dimmer Register Pointer Access Unit

This block is the register back end of a serial-bus LED dimmer. A byte-level bus engine hands it one strobe per transferred byte. After each start condition, the first byte written is taken as a control byte rather than as data. That byte carries a three-bit register pointer and an auto-increment enable. Every later data byte in the same transaction is written to the register the pointer selects, and every read request returns that register. When auto-increment is enabled, the pointer steps after each data byte. It wraps from the last register back to the first, so a master can program the whole map in one burst.

The map holds seven registers, and the address order matters because the pointer steps through it:

| Address | Register |
|---|---|
| 0 | live input pins, read-only |
| 1 | blink prescaler A |
| 2 | blink duty A |
| 3 | blink prescaler B |
| 4 | blink duty B |
| 5 | LED source selector, low lanes |
| 6 | LED source selector, high lanes |

The prescaler, duty and selector values go out on dedicated ports to the blink generators and output drivers. The control byte is also visible on its own port. Reset loads defaults that leave every LED off.

Top module: `ledreg_ptr_access`

## Requirements
- R1: After synchronous reset, ctrl_o is 0x00 (pointer 0, auto-increment off), both prescalers are 0x00, both duty registers are 0x80, and both selectors are 0x00 (all LEDs off).
- R2: The first wr_i after a start_i is stored as the control byte. ctrl_o then shows bit 4 = wdata_i[4] (auto-increment flag), bits 2:0 = wdata_i[2:0] (pointer), and bits 7:5 and 3 as zero.
- R3: A wr_i that is not the first byte after a start writes wdata_i into the register at the pointer. The registers sit at 1 = prescaler A, 2 = duty A, 3 = prescaler B, 4 = duty B, 5 = selector low, 6 = selector high. The new value is visible on the output port the next cycle.
- R4: With auto-increment set, each data write and each read moves the pointer up by one, and the pointer wraps from 6 to 0.
- R5: With auto-increment clear, data writes and reads leave the pointer unchanged, so repeated bytes go to the same register.
- R6: A data write at pointer 0 changes no register. With auto-increment set, the pointer still advances.
- R7: A rd_i returns the selected register on rdata_o in the following cycle. At pointer 0 it returns in_pins_i as sampled in the rd_i cycle.
- R8: A read after a repeated start returns data from the current pointer and leaves the control byte unchanged.
- R9: Pointer 7 selects no register: reads return 0x00, writes are ignored, and with auto-increment set the pointer advances to 0.
- R10: start_i takes priority over wr_i and rd_i in the same cycle, and wr_i takes priority over rd_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| start_i | input | 1 | start or repeated start seen on the bus |
| wr_i | input | 1 | written byte strobe |
| wdata_i | input | 8 | written byte |
| rd_i | input | 1 | read byte request |
| in_pins_i | input | 8 | live pin levels for the input register |
| rdata_o | output | 8 | read data, valid the cycle after rd_i |
| ctrl_o | output | 8 | control byte: flag in bit 4, pointer in bits 2:0 |
| psc0_o | output | 8 | blink prescaler A |
| pwm0_o | output | 8 | blink duty A |
| psc1_o | output | 8 | blink prescaler B |
| pwm1_o | output | 8 | blink duty B |
| lsel0_o | output | 8 | LED source selector, low lanes |
| lsel1_o | output | 8 | LED source selector, high lanes |

## Verification
The bench targets the pointer wrap from 6 to 0 and the out-of-map pointer 7. A design that wraps at 7, or stalls at 7, would send a burst's seventh byte to the wrong register. It also writes at pointer 0. A design that stored that byte would corrupt a neighbour, or one that skipped the advance would shift the whole burst. Repeated-start reads are checked so that a design which re-captured the control byte would be caught by its moved pointer. Random mixes of starts, writes and reads with the flag on and off check that no stray pointer step creeps in.

// File: rtl/lp_pkg.sv
package lp_pkg;

    localparam int DATA_W   = 8;
    localparam int PTR_W    = 3;
    localparam int NUM_REGS = 7;
    localparam int AI_BIT   = 4;
    localparam logic [DATA_W-1:0] DUTY_DEFAULT = 8'h80;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [PTR_W-1:0]  ptr_t;

    typedef enum logic [PTR_W-1:0] {
        REG_INPUT = 3'd0,
        REG_PSC_A = 3'd1,
        REG_DUTY_A = 3'd2,
        REG_PSC_B = 3'd3,
        REG_DUTY_B = 3'd4,
        REG_SEL_LO = 3'd5,
        REG_SEL_HI = 3'd6
    } reg_id_e;

    typedef enum logic {
        PH_CTRL = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

    typedef struct packed {
        logic ai;
        ptr_t ptr;
    } ctrl_t;

    typedef struct packed {
        logic  wr;
        logic  rd;
        ptr_t  addr;
        byte_t data;
    } acc_t;

    // Next pointer: steps through the map and folds back to zero after the
    // last real register (an out-of-map pointer folds to zero as well).
    function automatic ptr_t ptr_next(input ptr_t p);
        if (p >= ptr_t'(NUM_REGS - 1)) begin
            return '0;
        end
        return p + ptr_t'(1);
    endfunction

    function automatic byte_t reg_default(input int idx);
        if (idx == int'(REG_DUTY_A) || idx == int'(REG_DUTY_B)) begin
            return DUTY_DEFAULT;
        end
        return '0;
    endfunction

    function automatic byte_t ctrl_view(input ctrl_t c);
        byte_t v;
        v = '0;
        v[AI_BIT] = c.ai;
        v[PTR_W-1:0] = c.ptr;
        return v;
    endfunction

endpackage

// File: rtl/lp_ptr_ctrl.sv
module lp_ptr_ctrl
    import lp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start_i,
    input  logic  wr_i,
    input  byte_t wdata_i,
    input  logic  rd_i,
    output ctrl_t ctrl_q,
    output acc_t  acc_o
);

    phase_e phase_q;
    logic   data_wr;
    logic   data_rd;
    logic   ctrl_wr;

    always_comb begin
        ctrl_wr = wr_i && !start_i && (phase_q == PH_CTRL);
        data_wr = wr_i && !start_i && (phase_q == PH_DATA);
        data_rd = rd_i && !start_i && !wr_i;
        acc_o.wr   = data_wr;
        acc_o.rd   = data_rd;
        acc_o.addr = ctrl_q.ptr;
        acc_o.data = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_CTRL;
        end else if (start_i) begin
            phase_q <= PH_CTRL;
        end else if (wr_i || rd_i) begin
            phase_q <= PH_DATA;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q.ai  <= wdata_i[AI_BIT];
            ctrl_q.ptr <= wdata_i[PTR_W-1:0];
        end else if ((data_wr || data_rd) && ctrl_q.ai) begin
            ctrl_q.ptr <= ptr_next(ctrl_q.ptr);
        end
    end

endmodule

// File: rtl/lp_regfile.sv
module lp_regfile
    import lp_pkg::*;
#(
    parameter int N = NUM_REGS
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_i,
    input  ptr_t  addr_i,
    input  byte_t data_i,
    output byte_t regs_o [N]
);

    for (genvar i = 0; i < N; i++) begin : g_reg
        if (i == int'(REG_INPUT)) begin : g_ro
            // address 0 reflects pins; nothing is stored here
            assign regs_o[i] = '0;
        end else begin : g_rw
            byte_t q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= reg_default(i);
                end else if (wr_i && addr_i == ptr_t'(i)) begin
                    q <= data_i;
                end
            end
            assign regs_o[i] = q;
        end
    end

endmodule

// File: rtl/lp_rd_mux.sv
module lp_rd_mux
    import lp_pkg::*;
#(
    parameter int N = NUM_REGS
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  rd_i,
    input  ptr_t  addr_i,
    input  byte_t regs_i [N],
    input  byte_t pins_i,
    output byte_t rdata_q
);

    byte_t sel;

    always_comb begin
        sel = '0;
        for (int i = 0; i < N; i++) begin
            if (addr_i == ptr_t'(i)) begin
                sel = (i == int'(REG_INPUT)) ? pins_i : regs_i[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (rd_i) begin
            rdata_q <= sel;
        end
    end

endmodule

// File: rtl/ledreg_ptr_access.sv
module ledreg_ptr_access
    import lp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       wr_i,
    input  logic [7:0] wdata_i,
    input  logic       rd_i,
    input  logic [7:0] in_pins_i,
    output logic [7:0] rdata_o,
    output logic [7:0] ctrl_o,
    output logic [7:0] psc0_o,
    output logic [7:0] pwm0_o,
    output logic [7:0] psc1_o,
    output logic [7:0] pwm1_o,
    output logic [7:0] lsel0_o,
    output logic [7:0] lsel1_o
);

    ctrl_t ctrl_q;
    acc_t  acc;
    byte_t regs [NUM_REGS];

    lp_ptr_ctrl u_ptr (
        .clk    (clk),
        .rst    (rst),
        .start_i(start_i),
        .wr_i   (wr_i),
        .wdata_i(wdata_i),
        .rd_i   (rd_i),
        .ctrl_q (ctrl_q),
        .acc_o  (acc)
    );

    lp_regfile #(.N(NUM_REGS)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_i  (acc.wr),
        .addr_i(acc.addr),
        .data_i(acc.data),
        .regs_o(regs)
    );

    lp_rd_mux #(.N(NUM_REGS)) u_rd (
        .clk    (clk),
        .rst    (rst),
        .rd_i   (acc.rd),
        .addr_i (acc.addr),
        .regs_i (regs),
        .pins_i (in_pins_i),
        .rdata_q(rdata_o)
    );

    assign ctrl_o  = ctrl_view(ctrl_q);
    assign psc0_o  = regs[REG_PSC_A];
    assign pwm0_o  = regs[REG_DUTY_A];
    assign psc1_o  = regs[REG_PSC_B];
    assign pwm1_o  = regs[REG_DUTY_B];
    assign lsel0_o = regs[REG_SEL_LO];
    assign lsel1_o = regs[REG_SEL_HI];

endmodule

// File: rtl/lp_access_chk.sv
module lp_access_chk (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       wr_i,
    input logic [7:0] wdata_i,
    input logic       rd_i,
    input logic [7:0] in_pins_i,
    input logic [7:0] rdata_o,
    input logic [7:0] ctrl_o,
    input logic [7:0] psc0_o,
    input logic [7:0] pwm0_o,
    input logic [7:0] psc1_o,
    input logic [7:0] pwm1_o,
    input logic [7:0] lsel0_o,
    input logic [7:0] lsel1_o
);

    // independent tracker of "next write is the control byte"
    logic expect_ctrl;
    logic data_acc;
    logic [47:0] all_regs;

    always_ff @(posedge clk) begin
        if (rst) begin
            expect_ctrl <= 1'b1;
        end else if (start_i) begin
            expect_ctrl <= 1'b1;
        end else if (wr_i || rd_i) begin
            expect_ctrl <= 1'b0;
        end
    end

    assign data_acc = !start_i && ((wr_i && !expect_ctrl) || (rd_i && !wr_i));
    assign all_regs = {psc0_o, pwm0_o, psc1_o, pwm1_o, lsel0_o, lsel1_o};

    p_reset_defaults_r1: assert property (@(posedge clk)
        $past(rst) |-> (ctrl_o == 8'h00 && psc0_o == 8'h00 && pwm0_o == 8'h80 &&
                        psc1_o == 8'h00 && pwm1_o == 8'h80 &&
                        lsel0_o == 8'h00 && lsel1_o == 8'h00));

    p_ctrl_capture_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !start_i && expect_ctrl) |=>
            (ctrl_o == {3'b000, $past(wdata_i[4]), 1'b0, $past(wdata_i[2:0])}));

    p_ptr_step_r4: assert property (@(posedge clk) disable iff (rst)
        (data_acc && ctrl_o[4] && ctrl_o[2:0] < 3'd6) |=>
            (ctrl_o[2:0] == $past(ctrl_o[2:0]) + 3'd1));

    p_ptr_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (data_acc && ctrl_o[4] && ctrl_o[2:0] >= 3'd6) |=> (ctrl_o[2:0] == 3'd0));

    p_ptr_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (data_acc && !ctrl_o[4]) |=> $stable(ctrl_o));

    p_input_ro_r6: assert property (@(posedge clk) disable iff (rst)
        (data_acc && wr_i && ctrl_o[2:0] == 3'd0) |=> $stable(all_regs));

    p_input_read_r7: assert property (@(posedge clk) disable iff (rst)
        (data_acc && !wr_i && ctrl_o[2:0] == 3'd0) |=> (rdata_o == $past(in_pins_i)));

    p_hole_read_r9: assert property (@(posedge clk) disable iff (rst)
        (data_acc && !wr_i && ctrl_o[2:0] == 3'd7) |=> (rdata_o == 8'h00));

    p_start_wins_r10: assert property (@(posedge clk) disable iff (rst)
        start_i |=> ($stable(ctrl_o) && $stable(all_regs)));

endmodule

bind ledreg_ptr_access lp_access_chk u_chk (.*);

// File: tb/ledreg_ptr_access_tb.sv
`timescale 1ns/1ps
module ledreg_ptr_access_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       start_i = 1'b0;
    logic       wr_i = 1'b0;
    logic [7:0] wdata_i = '0;
    logic       rd_i = 1'b0;
    logic [7:0] in_pins_i = '0;
    logic [7:0] rdata_o, ctrl_o, psc0_o, pwm0_o, psc1_o, pwm1_o, lsel0_o, lsel1_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model
    logic [7:0] m_reg [7];
    logic [2:0] m_ptr;
    logic       m_ai;
    bit         m_first;

    always #2.5 clk = ~clk;

    ledreg_ptr_access u_dut (.*);

    function automatic logic [2:0] nxt(input logic [2:0] p);
        return (p >= 3'd6) ? 3'd0 : p + 3'd1;
    endfunction

    function automatic logic [7:0] exp_ctrl();
        return {3'b000, m_ai, 1'b0, m_ptr};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk(req, "ctrl", ctrl_o, exp_ctrl());
        chk(req, "psc0", psc0_o, m_reg[1]);
        chk(req, "pwm0", pwm0_o, m_reg[2]);
        chk(req, "psc1", psc1_o, m_reg[3]);
        chk(req, "pwm1", pwm1_o, m_reg[4]);
        chk(req, "lsel0", lsel0_o, m_reg[5]);
        chk(req, "lsel1", lsel1_o, m_reg[6]);
    endtask

    task automatic model_reset();
        m_reg[0] = 8'h00; m_reg[1] = 8'h00; m_reg[2] = 8'h80; m_reg[3] = 8'h00;
        m_reg[4] = 8'h80; m_reg[5] = 8'h00; m_reg[6] = 8'h00;
        m_ptr = 3'd0; m_ai = 1'b0; m_first = 1'b1;
    endtask

    task automatic do_start(input string req);
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        m_first = 1'b1;
        chk_all(req);
    endtask

    task automatic do_wr(input logic [7:0] b, input string req);
        @(negedge clk); wr_i = 1'b1; wdata_i = b;
        @(negedge clk); wr_i = 1'b0;
        if (m_first) begin
            m_ai = b[4]; m_ptr = b[2:0]; m_first = 1'b0;
        end else begin
            if (m_ptr >= 3'd1 && m_ptr <= 3'd6) m_reg[m_ptr] = b;
            if (m_ai) m_ptr = nxt(m_ptr);
        end
        chk_all(req);
    endtask

    task automatic do_rd(input logic [7:0] pins, input string req);
        logic [7:0] e;
        @(negedge clk); rd_i = 1'b1; in_pins_i = pins;
        e = (m_ptr == 3'd0) ? pins : (m_ptr == 3'd7) ? 8'h00 : m_reg[m_ptr];
        @(negedge clk); rd_i = 1'b0; in_pins_i = ~pins;
        m_first = 1'b0;
        if (m_ai) m_ptr = nxt(m_ptr);
        chk(req, "rdata", rdata_o, e);
        chk_all(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        rst = 1'b1;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_all("R1");

        // R2: control byte capture masks unused bits
        do_start("R2");
        do_wr(8'hFF, "R2");               // ai=1, ptr=7
        // R9: pointer 7 write ignored, advances to 0
        do_wr(8'h5A, "R9");
        do_start("R9");
        do_wr(8'h17, "R9");               // ptr 7 again
        do_rd(8'h33, "R9");               // reads 0, wraps to 0
        // R6: write at 0 ignored, pointer advances
        do_start("R6");
        do_wr(8'h10, "R6");
        do_wr(8'hEE, "R6");
        // R3/R4: burst through map from 1 and wrap
        for (int i = 0; i < 6; i++) do_wr(8'h21 + 8'(i), "R3");
        chk("R4", "ptr wrap", ctrl_o, 8'h10);
        // R7: read input pins at 0 then registers
        do_rd(8'hA5, "R7");
        do_rd(8'h00, "R7");
        // R8: repeated start then read keeps control
        do_start("R8");
        do_rd(8'h00, "R8");
        chk("R8", "ctrl kept", ctrl_o, 8'h13);
        // R5: no auto-increment, same register overwritten
        do_start("R5");
        do_wr(8'h04, "R5");
        do_wr(8'h11, "R5");
        do_wr(8'h22, "R5");
        do_rd(8'h00, "R5");
        chk("R5", "pwm1", pwm1_o, 8'h22);
        // R10: start with wr in same cycle -> start wins
        @(negedge clk); start_i = 1'b1; wr_i = 1'b1; wdata_i = 8'h99;
        @(negedge clk); start_i = 1'b0; wr_i = 1'b0;
        m_first = 1'b1;
        chk_all("R10");
        do_wr(8'h15, "R10");              // now captured as control

        // random mix
        for (int n = 0; n < 600; n++) begin
            int unsigned k;
            k = $urandom_range(0, 9);
            if (k == 0) do_start("R8");
            else if (k < 6) do_wr(8'($urandom), m_ai ? "R4" : "R5");
            else do_rd(8'($urandom), "R7");
        end

        // reset again mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        model_reset();
        chk_all("R1");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule